// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Core

This block models a single-ported synchronous static RAM with a registered read stage and byte-lane write control. Two active-low address strobes can open an access: one for the processor side and one for the controller side. Three chip enables must all be active, or the access is refused. When an access opens, the presented address is captured. The access can then carry on over the following cycles. A two-bit wrapping burst counter walks the low address bits in either interleaved or linear order.

Writes are opened by the controller strobe, or continue a burst that is already open. They store the whole word under the global write, or only the chosen 9-bit lanes under the byte-write controls. A processor-strobe start is always a read. Read data is registered one clock after the access. The shared data bus is modelled as an input bus, an output bus and an output-drive flag. The drive flag is dropped after any write cycle, whatever the output enable says.

Top module: `ssram_access_core`

## Requirements
- R1: A write starts when `strb_ctl_n`=0, `strb_cpu_n`=1 and all chip enables are active (`ce_a_n`=0, `ce_b`=1, `ce_c_n`=0) at a rising edge. When `strb_cpu_n`=0 with the enables active, a read starts at `addr`, and write controls have no effect on that cycle.
- R2: If a strobe is sampled low while any chip enable is inactive, nothing is written and the open access closes. Later cycles with no strobe then neither write nor drive data.
- R3: On a start cycle, the word at `addr` is accessed and `adv_n` is ignored.
- R4: With `gwr_n`=0, all four lanes of `din` are stored, whatever `bwen_n` and `lane_wen_n` are.
- R5: With `gwr_n`=1 and `bwen_n`=0, lane i (bits 9i+8..9i) is stored only when `lane_wen_n[i]`=0. Unselected lanes keep their old contents.
- R6: In the cycle after any write cycle, `dout_en` is 0, even when `oe_n`=0.
- R7: In the cycle after a read access cycle, `dout` holds the word read. `dout_en` is 1 only if `oe_n` was 0 at that edge.
- R8: With `lin_mode`=0, a continuation cycle with `adv_n`=0 accesses low address bits start XOR count. The count is 1, 2, 3, then wraps back to 0.
- R9: With `lin_mode`=1, a continuation cycle with `adv_n`=0 accesses low address bits (start + count) mod 4.
- R10: A continuation cycle (both strobes high, access open) with `adv_n`=1 accesses the same word as the previous access cycle.
- R11: After reset, `dout_en` is 0 and no access is open, so continuation cycles do nothing until a strobe starts an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_wen_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive flag for the shared bus |

## Verification
The bench builds the core with AW=4, which gives 16 words. It fills every word at the start, so each read is compared against a known value. The shallow space lets random strobes, enables and write masks hit every location, and every burst start phase in both orders. The two-bit count wraps often within a short run. LANES and LANE_W keep their defaults of four 9-bit lanes, so lane isolation is checked on the full 36-bit word.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_INC = 1'b1
  } burst_order_e;

  // low address bits for a given start phase and count
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input burst_order_e order);
    logic [1:0] r;
    if (order == ORDER_INC) r = start + cnt;
    else                    r = start ^ cnt;
    return r;
  endfunction

endpackage

// File: rtl/ssram_burst_ctr.sv
module ssram_burst_ctr
  import ssram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] start_low,
  input  logic       adv,
  input  logic       linear,
  output logic [1:0] cur_low,
  output logic [1:0] nxt_low
);

  logic [1:0]   start_q;
  logic [1:0]   cnt_q;
  burst_order_e order;

  assign order   = linear ? ORDER_INC : ORDER_XOR;
  assign cur_low = burst_low(start_q, cnt_q, order);
  assign nxt_low = burst_low(start_q, cnt_q + 2'd1, order);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= start_low;
      cnt_q   <= '0;
    end else if (adv) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  // R3: a freshly loaded burst points at the captured low bits in either order
  p_load_phase_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_low == $past(start_low)));

  // R10: without load or advance the position only moves if the order changed
  p_hold_pos_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ((linear != $past(linear)) || $stable(cur_low)));

endmodule

// File: rtl/ssram_lane.sv
module ssram_lane #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (rd) rdata <= mem[addr];
  end

endmodule

// File: rtl/ssram_access_core.sv
module ssram_access_core
  import ssram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lin_mode,
  input  logic [AW-1:0]           addr,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    adv_n,
  input  logic                    gwr_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        lane_wen_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DW = LANES * LANE_W;

  logic             sel, st_cpu, st_ctl, start, desel, cont;
  logic             open_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       cur_low, nxt_low;
  logic [AW-1:0]    eff_addr;
  logic [LANES-1:0] req_mask, wr_mask;
  logic             rd_acc;

  assign sel    = ~ce_a_n & ce_b & ~ce_c_n;
  assign st_cpu = sel & ~strb_cpu_n;
  assign st_ctl = sel & ~strb_ctl_n & strb_cpu_n;
  assign start  = st_cpu | st_ctl;
  assign desel  = ~sel & (~strb_cpu_n | ~strb_ctl_n);
  assign cont   = open_q & strb_cpu_n & strb_ctl_n;

  always_comb begin
    if (!gwr_n)       req_mask = '1;
    else if (!bwen_n) req_mask = ~lane_wen_n;
    else              req_mask = '0;
  end

  assign wr_mask = (st_ctl | cont) ? req_mask : '0;
  assign rd_acc  = (start | cont) & ~(|wr_mask);

  always_comb begin
    if (start)        eff_addr = addr;
    else if (!adv_n)  eff_addr = {base_q[AW-1:2], nxt_low};
    else              eff_addr = {base_q[AW-1:2], cur_low};
  end

  ssram_burst_ctr u_burst (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .start_low (addr[1:0]),
    .adv       (cont & ~adv_n),
    .linear    (lin_mode),
    .cur_low   (cur_low),
    .nxt_low   (nxt_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      base_q  <= '0;
      dout_en <= 1'b0;
    end else begin
      if (start) begin
        open_q <= 1'b1;
        base_q <= addr;
      end else if (desel) begin
        open_q <= 1'b0;
      end
      dout_en <= rd_acc & ~oe_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ssram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .we    (wr_mask[g]),
      .rd    (rd_acc),
      .addr  (eff_addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (dout[g*LANE_W +: LANE_W])
    );
  end

  // R6: a controller-strobe global write leaves the bus undriven next cycle
  p_wr_tristate_r6: assert property (@(posedge clk) disable iff (rst)
    (~ce_a_n && ce_b && ~ce_c_n && !strb_ctl_n && strb_cpu_n && !gwr_n)
    |=> !dout_en);

  // R2: a strobe seen while deselected never leads to driven data
  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!(~ce_a_n && ce_b && ~ce_c_n) && (!strb_cpu_n || !strb_ctl_n))
    |=> !dout_en);

  // R7: output enable high at the edge keeps the bus undriven
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dout_en);

  // R1: a processor-strobe start is a read and drives when enabled
  p_cpu_read_r1: assert property (@(posedge clk) disable iff (rst)
    (~ce_a_n && ce_b && ~ce_c_n && !strb_cpu_n && !oe_n) |=> dout_en);

endmodule

// File: tb/test_ssram_access_core.sv
`timescale 1ns/1ps
module test_ssram_access_core;

  localparam int AW = 4;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lin_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1;
  logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic          adv_n = 1'b1, gwr_n = 1'b1, bwen_n = 1'b1;
  logic [LN-1:0] lane_wen_n = '1;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ssram_access_core #(.AW(AW), .LANES(LN), .LANE_W(LW)) i_ssram_access_core (
    .clk(clk), .rst(rst), .lin_mode(lin_mode), .addr(addr),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .lane_wen_n(lane_wen_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  // behavioural reference state
  logic [DW-1:0] ref_mem [WORDS];
  bit            m_open = 0;
  int            m_base = 0;
  int            m_start = 0;
  int            m_cnt = 0;

  function automatic int order_low(int s, int k, bit lin);
    if (lin) return (s + k) % 4;
    return (s ^ (k % 4)) & 3;
  endfunction

  // one clock: predict, advance, compare after the edge
  task automatic cyc(input string tag);
    bit sel, scpu, sctl, st_cpu, st_ctl, desel, cont, rd;
    int eff;
    logic [LN-1:0] mask;
    logic [DW-1:0] exp_d;
    bit exp_en;
    sel    = !ce_a_n && ce_b && !ce_c_n;
    scpu   = !strb_cpu_n;
    sctl   = !strb_ctl_n;
    st_cpu = scpu && sel;
    st_ctl = sctl && !scpu && sel;
    desel  = (scpu || sctl) && !sel;
    cont   = m_open && !scpu && !sctl;
    if (!gwr_n) mask = '1;
    else if (!bwen_n) mask = ~lane_wen_n;
    else mask = '0;
    if (!(st_ctl || cont)) mask = '0;
    if (st_cpu || st_ctl) eff = int'(addr);
    else eff = (m_base & ~3) | order_low(m_start, adv_n ? m_cnt : m_cnt + 1, lin_mode);
    rd = (st_cpu || st_ctl || cont) && (mask == '0);
    exp_en = rd && !oe_n;
    exp_d  = ref_mem[eff];
    for (int i = 0; i < LN; i++)
      if (mask[i]) ref_mem[eff][i*LW +: LW] = din[i*LW +: LW];
    if (st_cpu || st_ctl) begin
      m_open = 1; m_base = int'(addr); m_start = int'(addr) & 3; m_cnt = 0;
    end else if (desel) begin
      m_open = 0;
    end else if (cont && !adv_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(posedge clk); #1;
    n_cmp++;
    if (dout_en !== exp_en) begin
      n_bad++;
      $display("FAIL %s dout_en got %0b expected %0b", tag, dout_en, exp_en);
    end
    if (exp_en) begin
      n_cmp++;
      if (dout !== exp_d) begin
        n_bad++;
        $display("FAIL %s dout got %h expected %h", tag, dout, exp_d);
      end
    end
  endtask

  task automatic idle_in();
    strb_cpu_n = 1; strb_ctl_n = 1; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    adv_n = 1; gwr_n = 1; bwen_n = 1; lane_wen_n = '1; oe_n = 0;
  endtask

  task automatic gwrite(input int a, input logic [DW-1:0] d, input string tag);
    idle_in(); addr = AW'(a); strb_ctl_n = 0; gwr_n = 0; din = d;
    cyc(tag);
  endtask

  task automatic read_at(input int a, input bit oe, input string tag);
    idle_in(); addr = AW'(a); strb_cpu_n = 0; oe_n = oe;
    cyc(tag);
  endtask

  task automatic burst_read(input int a, input bit lin, input string tag);
    idle_in(); lin_mode = lin;
    read_at(a, 0, tag);
    for (int i = 0; i < 4; i++) begin
      idle_in(); adv_n = 0; cyc(tag);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    n_cmp++;
    if (dout_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset dout_en got %0b expected 0", dout_en);
    end
    rst = 0;
    // R11: no open access, so continuation cycles do nothing
    idle_in(); gwr_n = 0; din = '1; cyc("R11");
    idle_in(); cyc("R11");
    // R1, R4, R6: controller-strobe global writes fill the array, oe low
    for (int a = 0; a < WORDS; a++)
      gwrite(a, {4{LW'(a * 37 + 5)}}, "R1/R6");
    read_at(5, 0, "R7");
    read_at(5, 1, "R7");
    // R1: both strobes low with write asserted is a read
    idle_in(); addr = 3; strb_cpu_n = 0; strb_ctl_n = 0; gwr_n = 0; din = '0;
    cyc("R1");
    read_at(3, 0, "R1");
    // R2: deselect blocks write and closes the access
    idle_in(); addr = 2; strb_ctl_n = 0; ce_b = 0; gwr_n = 0; din = '0; cyc("R2");
    idle_in(); gwr_n = 0; din = '0; cyc("R2");
    idle_in(); ce_c_n = 1; strb_cpu_n = 0; addr = 2; cyc("R2");
    read_at(2, 0, "R2");
    // R5: lanes 0 and 2 only
    idle_in(); addr = 6; strb_ctl_n = 0; bwen_n = 0; lane_wen_n = 4'b1010;
    din = {4{9'h1AB}}; cyc("R5");
    read_at(6, 0, "R5");
    // R4: global write overrides byte controls
    idle_in(); addr = 7; strb_ctl_n = 0; gwr_n = 0; bwen_n = 0; lane_wen_n = 4'b1110;
    din = 36'h9_8765_4321; cyc("R4");
    read_at(7, 0, "R4");
    // R3: advance ignored on a start cycle
    idle_in(); addr = 9; strb_cpu_n = 0; adv_n = 0; cyc("R3");
    // R8 / R9: orders from start phase 01
    burst_read(9, 0, "R8");
    burst_read(9, 1, "R9");
    burst_read(14, 1, "R9");
    // R10: hold without advance
    read_at(10, 0, "R10");
    idle_in(); cyc("R10");
    idle_in(); adv_n = 0; cyc("R10");
    idle_in(); cyc("R10");
    // R8: burst write continuation, then read back
    idle_in(); lin_mode = 0; addr = 13; strb_ctl_n = 0; gwr_n = 0; din = 36'h1_1111_1111; cyc("R8");
    idle_in(); adv_n = 0; gwr_n = 0; din = 36'h2_2222_2222; cyc("R8");
    idle_in(); adv_n = 0; bwen_n = 0; lane_wen_n = 4'b0111; din = 36'h3_3333_3333; cyc("R8");
    for (int a = 12; a < 16; a++) read_at(a, 0, "R8");
    // mixed traffic across all requirements
    for (int i = 0; i < 600; i++) begin
      lin_mode   = 1'($urandom_range(0, 1));
      addr       = AW'($urandom_range(0, WORDS - 1));
      strb_cpu_n = ($urandom_range(0, 3) != 0);
      strb_ctl_n = ($urandom_range(0, 2) != 0);
      ce_a_n     = ($urandom_range(0, 9) == 0);
      ce_b       = ($urandom_range(0, 9) != 0);
      ce_c_n     = ($urandom_range(0, 9) == 0);
      adv_n      = 1'($urandom_range(0, 1));
      gwr_n      = ($urandom_range(0, 4) != 0);
      bwen_n     = 1'($urandom_range(0, 1));
      lane_wen_n = LN'($urandom_range(0, 15));
      oe_n       = ($urandom_range(0, 3) == 0);
      din        = {4'($urandom_range(0, 15)), 32'($urandom)};
      cyc("R1..mix");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule